// File: doc/BRIEF.md
# Reference-Counted Instruction Fetch Buffer

This block sits between an in-order fetch stage and the instruction cache port. It keeps a small set of recently fetched cache blocks. Each block carries a tag made of an address-space identifier and a block-aligned address. When a fetch starts, the buffer checks whether the block is already on its way from memory or already held. If it is, the request is merged onto that block and no memory read goes out. If it is not, the buffer issues one full-block read and opens an in-flight entry for it.

Every entry counts the fetches still waiting on it. The limit on new misses counts two things: in-flight entries and held entries that still have waiters. When a fetch completes, the buffer picks one instruction word out of the block. A completing miss moves its block into the held set. If the held set is full, the completion evicts the least recently used held block that has no waiters.

A squash takes one waiter away from an entry. A flush empties the buffer. A fetch that already carries a fault skips all buffer logic.

Top module: `fbuf_top`

## Requirements
- R1: A lookup hits only when both the address-space ID and the block tag (address bits above the block offset) of an entry equal those of the request.
- R2: An accepted start request that matches an in-flight entry returns `init_ok`=1 and `init_shared`=1, adds one waiter and issues no read. This holds even when occupancy is at capacity.
- R3: A start request that matches nothing, with occupancy below `CAP`, returns `init_ok`=1 and `init_shared`=0. In the same cycle it raises `mem_rd_valid` with the request's ID and the block-aligned address. It allocates an in-flight entry with one waiter.
- R4: Occupancy is the number of in-flight entries plus the number of held entries with waiters. When occupancy is at or above `CAP`, a start request that does not match an in-flight entry is refused: `init_ok`=0 and no read. This applies even if the block is held.
- R5: While `mem_blocked` is high, every start request is refused with no lookup and no read.
- R6: A fill stores the block in the matching in-flight entry. Two completions stall (`cmp_done`=0): a shared completion whose block is not yet held, and a miss completion whose data has not arrived.
- R7: A successful completion raises `cmp_done` in the same cycle. `cmp_word` is word number (address offset / `INSN_BYTES`) of the block, where word k occupies block bits [k*32+31 : k*32]. The completion removes one waiter and marks the entry most recently used.
- R8: A miss completion moves its entry into the held set. If `CAP` blocks are already held, it first evicts the least recently used held block with zero waiters, skipping referenced ones. The held count never exceeds `CAP`.
- R9: A squash removes one waiter from the matching held entry, or, if no held entry matches, from the matching in-flight entry. An in-flight entry that drops to zero waiters is freed, so a later start for it issues a new read and a late fill for it is ignored.
- R10: A start request with `init_fault` set is accepted (`init_ok`=1, `init_shared`=0, no read). A completion with `cmp_fault` set returns `cmp_done`=1 and `cmp_word`=0. Neither changes any entry.
- R11: `flush` invalidates every held and in-flight entry.
- R12: An attempt to remove a waiter from an entry whose count is already zero leaves the count unchanged. It sets `err_underflow`, which stays set until reset.
- R13: When ports collide in one cycle, squash beats completion and completion beats start. The losing start is refused and the losing completion stalls.
- R14: After reset the buffer is empty, `err_underflow` is 0 and all responses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_valid | input | 1 | Start-fetch request |
| init_asid | input | ASID_W | Request address-space ID |
| init_addr | input | ADDR_W | Fetch byte address |
| init_fault | input | 1 | Request already faulted |
| init_ok | output | 1 | Start accepted (0 = retry) |
| init_shared | output | 1 | Served through the buffer, no read |
| mem_rd_valid | output | 1 | Full-block read issued |
| mem_rd_asid | output | ASID_W | Read ID |
| mem_rd_addr | output | ADDR_W | Block-aligned read address |
| mem_blocked | input | 1 | Memory port cannot take a read |
| fill_valid | input | 1 | Block data returning |
| fill_asid | input | ASID_W | Fill ID |
| fill_addr | input | ADDR_W | Fill address |
| fill_data | input | BLK_BYTES*8 | Whole block |
| cmp_valid | input | 1 | Complete-fetch request |
| cmp_asid | input | ASID_W | Completion ID |
| cmp_addr | input | ADDR_W | Completion fetch address |
| cmp_shared | input | 1 | Request was marked shared at start |
| cmp_fault | input | 1 | Request already faulted |
| cmp_done | output | 1 | Completion succeeded (0 = stall) |
| cmp_word | output | INSN_BYTES*8 | Selected instruction word |
| sq_valid | input | 1 | Squash one request |
| sq_asid | input | ASID_W | Squash ID |
| sq_addr | input | ADDR_W | Squash address |
| flush | input | 1 | Invalidate all entries |
| err_underflow | output | 1 | Sticky waiter-count underflow |

## Verification
Start responses, read issue and completion responses are combinational, so each is due in the cycle its request is presented. The bench drives a request just after a rising edge and samples at the following falling edge. Entry updates from allocation, fill, squash, eviction and flush land on that rising edge. They are therefore observed through the request of a later cycle, for example a second start that misses or hits. `err_underflow` rises one edge after the offending squash and is sampled in the next cycle and again one idle cycle later.

// File: rtl/fb_pkg.sv
// Package: shared types for the fetch buffer.
package fb_pkg;
    // Source of the word returned by a completion
    typedef enum logic [1:0] {
        CP_IDLE   = 2'd0,
        CP_BYPASS = 2'd1,
        CP_SHARED = 2'd2,
        CP_MISS   = 2'd3
    } cmp_path_e;
endpackage

// File: rtl/fb_find.sv
// fb_find: priority encoder. Reports whether any request bit is set and
// the index of the lowest one. Assumes N >= 2.
module fb_find #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit wins
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/fb_lru.sv
// fb_lru: recency ranks over all entries (0 = least recent). A touch moves
// one entry to the top rank. The victim is the candidate with the lowest
// rank. Ranks always form a permutation of 0..N-1.
module fb_lru #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch,
    input  logic [IW-1:0] touch_idx,
    input  logic [N-1:0]  cand,
    output logic          vic_hit,
    output logic [IW-1:0] vic_idx
);
    logic [IW-1:0] rank_q [N];

    // Rank update: the touched entry goes to the top, those above it shift down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) rank_q[i] <= IW'(i);
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)
                    rank_q[i] <= IW'(N - 1);
                else if (rank_q[i] > rank_q[touch_idx])
                    rank_q[i] <= rank_q[i] - 1'b1;
            end
        end
    end

    // Victim selection: lowest rank among the candidates
    always_comb begin
        logic [IW-1:0] best;
        best    = '1;
        vic_hit = 1'b0;
        vic_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!vic_hit || rank_q[i] < best)) begin
                vic_hit = 1'b1;
                vic_idx = IW'(i);
                best    = rank_q[i];
            end
        end
    end
endmodule

// File: rtl/fbuf_top.sv
// fbuf_top: reference-counted instruction fetch buffer.
// Entries are either in flight (read issued) or held (moved in at completion).
// Assumes: one of squash/complete/start acts per cycle (in that priority), the
// memory returns whole blocks tagged like the request, and BLK_BYTES > INSN_BYTES.
module fbuf_top
    import fb_pkg::*;
#(
    parameter int ASID_W     = 4,
    parameter int ADDR_W     = 16,
    parameter int BLK_BYTES  = 16,
    parameter int INSN_BYTES = 4,
    parameter int CAP        = 2,
    parameter int CNT_W      = 4,
    localparam int NE     = 2 * CAP,
    localparam int IW     = $clog2(NE),
    localparam int OFF_W  = $clog2(BLK_BYTES),
    localparam int IB_W   = $clog2(INSN_BYTES),
    localparam int TAG_W  = ADDR_W - OFF_W,
    localparam int BLK_W  = BLK_BYTES * 8,
    localparam int WORD_W = INSN_BYTES * 8,
    localparam int WIX_W  = OFF_W - IB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_valid,
    input  logic [ASID_W-1:0] init_asid,
    input  logic [ADDR_W-1:0] init_addr,
    input  logic              init_fault,
    output logic              init_ok,
    output logic              init_shared,
    output logic              mem_rd_valid,
    output logic [ASID_W-1:0] mem_rd_asid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_blocked,
    input  logic              fill_valid,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [BLK_W-1:0]  fill_data,
    input  logic              cmp_valid,
    input  logic [ASID_W-1:0] cmp_asid,
    input  logic [ADDR_W-1:0] cmp_addr,
    input  logic              cmp_shared,
    input  logic              cmp_fault,
    output logic              cmp_done,
    output logic [WORD_W-1:0] cmp_word,
    input  logic              sq_valid,
    input  logic [ASID_W-1:0] sq_asid,
    input  logic [ADDR_W-1:0] sq_addr,
    input  logic              flush,
    output logic              err_underflow
);
    // Entry state
    logic [NE-1:0]     pend_q, res_q, vld_q;
    logic [ASID_W-1:0] asid_q [NE];
    logic [TAG_W-1:0]  tag_q  [NE];
    logic [CNT_W-1:0]  cnt_q  [NE];
    logic [BLK_W-1:0]  data_q [NE];
    logic              err_q;

    logic [TAG_W-1:0] init_tag, cmp_tag, sq_tag, fill_tag;
    assign init_tag = init_addr[ADDR_W-1:OFF_W];
    assign cmp_tag  = cmp_addr[ADDR_W-1:OFF_W];
    assign sq_tag   = sq_addr[ADDR_W-1:OFF_W];
    assign fill_tag = fill_addr[ADDR_W-1:OFF_W];

    // Per-entry tag comparisons
    logic [NE-1:0] ip_m, ir_m, cp_m, cr_m, sp_m, sr_m, fp_m, nz_m;
    for (genvar g = 0; g < NE; g++) begin : g_cmp
        logic ie, ce, se, fe;
        assign ie = (asid_q[g] == init_asid) && (tag_q[g] == init_tag);
        assign ce = (asid_q[g] == cmp_asid)  && (tag_q[g] == cmp_tag);
        assign se = (asid_q[g] == sq_asid)   && (tag_q[g] == sq_tag);
        assign fe = (asid_q[g] == fill_asid) && (tag_q[g] == fill_tag);
        assign ip_m[g] = pend_q[g] && ie;
        assign ir_m[g] = res_q[g]  && ie;
        assign cp_m[g] = pend_q[g] && ce;
        assign cr_m[g] = res_q[g]  && ce;
        assign sp_m[g] = pend_q[g] && se;
        assign sr_m[g] = res_q[g]  && se;
        assign fp_m[g] = pend_q[g] && fe;
        assign nz_m[g] = (cnt_q[g] != '0);
    end

    logic          ip_hit, ir_hit, cp_hit, cr_hit, sp_hit, sr_hit, fp_hit, fr_hit;
    logic [IW-1:0] ip_idx, ir_idx, cp_idx, cr_idx, sp_idx, sr_idx, fp_idx, fr_idx;
    fb_find #(.N(NE)) u_ip (.req(ip_m), .hit(ip_hit), .idx(ip_idx));
    fb_find #(.N(NE)) u_ir (.req(ir_m), .hit(ir_hit), .idx(ir_idx));
    fb_find #(.N(NE)) u_cp (.req(cp_m), .hit(cp_hit), .idx(cp_idx));
    fb_find #(.N(NE)) u_cr (.req(cr_m), .hit(cr_hit), .idx(cr_idx));
    fb_find #(.N(NE)) u_sp (.req(sp_m), .hit(sp_hit), .idx(sp_idx));
    fb_find #(.N(NE)) u_sr (.req(sr_m), .hit(sr_hit), .idx(sr_idx));
    fb_find #(.N(NE)) u_fp (.req(fp_m), .hit(fp_hit), .idx(fp_idx));
    fb_find #(.N(NE)) u_fr (.req(~(pend_q | res_q)), .hit(fr_hit), .idx(fr_idx));

    logic          touch_en, vic_hit;
    logic [IW-1:0] touch_idx, vic_idx;
    fb_lru #(.N(NE)) u_lru (
        .clk(clk), .rst_n(rst_n), .touch(touch_en), .touch_idx(touch_idx),
        .cand(res_q & ~nz_m), .vic_hit(vic_hit), .vic_idx(vic_idx)
    );

    // Occupancy: in-flight entries plus held entries with waiters
    logic [IW:0] occ, res_cnt;
    always_comb begin
        occ     = '0;
        res_cnt = '0;
        for (int i = 0; i < NE; i++) begin
            occ     = occ + (IW+1)'(pend_q[i] || (res_q[i] && nz_m[i]));
            res_cnt = res_cnt + (IW+1)'(res_q[i]);
        end
    end

    logic init_act, cmp_act, sq_act;
    assign sq_act   = sq_valid && !flush;
    assign cmp_act  = cmp_valid && !sq_valid && !flush;
    assign init_act = init_valid && !cmp_valid && !sq_valid && !flush;

    // Start path: in-flight search first, then held search under capacity
    logic inc_en, alloc_en;
    logic [IW-1:0] inc_idx;
    always_comb begin
        init_ok = 1'b0; init_shared = 1'b0; inc_en = 1'b0; alloc_en = 1'b0;
        inc_idx = ip_idx;
        if (init_act && !mem_blocked) begin
            if (init_fault) begin
                init_ok = 1'b1;
            end else if (ip_hit) begin
                init_ok = 1'b1; init_shared = 1'b1; inc_en = 1'b1;
            end else if (occ < (IW+1)'(CAP)) begin
                if (ir_hit) begin
                    init_ok = 1'b1; init_shared = 1'b1; inc_en = 1'b1; inc_idx = ir_idx;
                end else if (fr_hit) begin
                    init_ok = 1'b1; alloc_en = 1'b1;
                end
            end
        end
    end
    assign mem_rd_valid = alloc_en;
    assign mem_rd_asid  = init_asid;
    assign mem_rd_addr  = {init_tag, OFF_W'(0)};

    // Completion and squash path: choose entry, waiter decrement, eviction
    cmp_path_e     path;
    logic          dec_en, dec_free, evict_en, promote_en;
    logic [IW-1:0] dec_idx;
    always_comb begin
        path = CP_IDLE; dec_en = 1'b0; dec_free = 1'b0; dec_idx = cr_idx;
        evict_en = 1'b0; promote_en = 1'b0;
        if (sq_act) begin
            if (sr_hit) begin
                dec_en = 1'b1; dec_idx = sr_idx;
            end else if (sp_hit) begin
                dec_en = 1'b1; dec_idx = sp_idx; dec_free = 1'b1;
            end
        end else if (cmp_act) begin
            if (cmp_fault) begin
                path = CP_BYPASS;
            end else if (cmp_shared) begin
                if (cr_hit) begin
                    path = CP_SHARED; dec_en = 1'b1; dec_idx = cr_idx;
                end
            end else if (cp_hit && vld_q[cp_idx]) begin
                if (res_cnt < (IW+1)'(CAP) || vic_hit) begin
                    path = CP_MISS; dec_en = 1'b1; dec_idx = cp_idx; promote_en = 1'b1;
                    evict_en = (res_cnt >= (IW+1)'(CAP));
                end
            end
        end
    end
    assign touch_en  = (path == CP_SHARED) || (path == CP_MISS);
    assign touch_idx = dec_idx;
    assign cmp_done  = (path != CP_IDLE);

    // Word select from the completing entry
    logic [WIX_W-1:0] widx;
    assign widx = cmp_addr[OFF_W-1:IB_W];
    always_comb begin
        cmp_word = '0;
        if (touch_en) cmp_word = data_q[dec_idx][widx*WORD_W +: WORD_W];
    end

    // Entry state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0; res_q <= '0; vld_q <= '0; err_q <= 1'b0;
            for (int i = 0; i < NE; i++) begin
                asid_q[i] <= '0; tag_q[i] <= '0; cnt_q[i] <= '0;
            end
        end else if (flush) begin
            pend_q <= '0; res_q <= '0; vld_q <= '0;
        end else begin
            if (fill_valid && fp_hit) begin
                data_q[fp_idx] <= fill_data;
                vld_q[fp_idx]  <= 1'b1;
            end
            if (alloc_en) begin
                pend_q[fr_idx] <= 1'b1; vld_q[fr_idx] <= 1'b0;
                asid_q[fr_idx] <= init_asid; tag_q[fr_idx] <= init_tag;
                cnt_q[fr_idx]  <= CNT_W'(1);
            end
            if (inc_en) cnt_q[inc_idx] <= cnt_q[inc_idx] + 1'b1;
            if (evict_en) res_q[vic_idx] <= 1'b0;
            if (promote_en) begin
                pend_q[cp_idx] <= 1'b0; res_q[cp_idx] <= 1'b1;
            end
            if (dec_en) begin
                if (cnt_q[dec_idx] == '0) begin
                    err_q <= 1'b1;
                end else begin
                    cnt_q[dec_idx] <= cnt_q[dec_idx] - 1'b1;
                    if (dec_free && cnt_q[dec_idx] == CNT_W'(1)) pend_q[dec_idx] <= 1'b0;
                end
            end
        end
    end
    assign err_underflow = err_q;
endmodule

// File: rtl/fbuf_chk.sv
// fbuf_chk: protocol and state properties of fbuf_top, attached with bind.
module fbuf_chk #(
    parameter int NE  = 4,
    parameter int CAP = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          init_valid,
    input logic          init_ok,
    input logic          init_shared,
    input logic          mem_rd_valid,
    input logic          mem_blocked,
    input logic          cmp_valid,
    input logic          cmp_done,
    input logic          sq_valid,
    input logic          flush,
    input logic          err_underflow,
    input logic [NE-1:0] pend_q,
    input logic [NE-1:0] res_q
);
    a_r3_read_means_miss_accept: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (init_ok && !init_shared));
    a_r5_blocked_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (init_valid && mem_blocked) |-> !init_ok);
    a_r13_start_loses: assert property (@(posedge clk) disable iff (!rst_n)
        (init_valid && (cmp_valid || sq_valid)) |-> (!init_ok && !mem_rd_valid));
    a_r13_cmp_loses: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && sq_valid) |-> !cmp_done);
    a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (pend_q == '0 && res_q == '0));
    a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |=> err_underflow);
    a_r8_held_bound: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(res_q) <= CAP);
    a_r4_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pend_q) <= CAP);
    a_r8_state_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & res_q) == '0);
endmodule

bind fbuf_top fbuf_chk #(.NE(NE), .CAP(CAP)) u_chk (
    .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_ok(init_ok),
    .init_shared(init_shared), .mem_rd_valid(mem_rd_valid), .mem_blocked(mem_blocked),
    .cmp_valid(cmp_valid), .cmp_done(cmp_done), .sq_valid(sq_valid), .flush(flush),
    .err_underflow(err_underflow), .pend_q(pend_q), .res_q(res_q)
);

// File: tb/fbuf_top_tb_top.sv
// Directed bench for fbuf_top with default parameters (CAP=2, 16-byte blocks).
module fbuf_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic init_valid = 0, init_fault = 0, mem_blocked = 0;
    logic [3:0] init_asid = 0, fill_asid = 0, cmp_asid = 0, sq_asid = 0;
    logic [15:0] init_addr = 0, fill_addr = 0, cmp_addr = 0, sq_addr = 0;
    logic fill_valid = 0, cmp_valid = 0, cmp_shared = 0, cmp_fault = 0;
    logic sq_valid = 0, flush = 0;
    logic [127:0] fill_data = 0;
    logic init_ok, init_shared, mem_rd_valid, cmp_done, err_underflow;
    logic [3:0] mem_rd_asid;
    logic [15:0] mem_rd_addr;
    logic [31:0] cmp_word;
    int checks = 0, errors = 0;

    fbuf_top dut_i (
        .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_asid(init_asid),
        .init_addr(init_addr), .init_fault(init_fault), .init_ok(init_ok),
        .init_shared(init_shared), .mem_rd_valid(mem_rd_valid), .mem_rd_asid(mem_rd_asid),
        .mem_rd_addr(mem_rd_addr), .mem_blocked(mem_blocked), .fill_valid(fill_valid),
        .fill_asid(fill_asid), .fill_addr(fill_addr), .fill_data(fill_data),
        .cmp_valid(cmp_valid), .cmp_asid(cmp_asid), .cmp_addr(cmp_addr),
        .cmp_shared(cmp_shared), .cmp_fault(cmp_fault), .cmp_done(cmp_done),
        .cmp_word(cmp_word), .sq_valid(sq_valid), .sq_asid(sq_asid), .sq_addr(sq_addr),
        .flush(flush), .err_underflow(err_underflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkw(input logic [3:0] a, input logic [15:0] addr, input int k);
        return {8'hA5, a, addr[15:4], 8'(k)};
    endfunction

    task automatic nxt();
        @(posedge clk); #1;
    endtask

    // Start request; checks accept, shared flag and read issue in the same cycle
    task automatic t_init(input logic [3:0] a, input logic [15:0] ad, input logic f,
                          input logic eok, input logic esh, input logic erd, input string req);
        init_valid = 1; init_asid = a; init_addr = ad; init_fault = f;
        @(negedge clk);
        chk({req, " init_ok"}, 32'(init_ok), 32'(eok));
        chk({req, " init_shared"}, 32'(init_shared), 32'(esh));
        chk({req, " mem_rd_valid"}, 32'(mem_rd_valid), 32'(erd));
        if (erd) begin
            chk({req, " rd_addr"}, 32'(mem_rd_addr), 32'({ad[15:4], 4'h0}));
            chk({req, " rd_asid"}, 32'(mem_rd_asid), 32'(a));
        end
        nxt();
        init_valid = 0; init_fault = 0;
    endtask

    task automatic t_cmp(input logic [3:0] a, input logic [15:0] ad, input logic sh,
                         input logic f, input logic edone, input logic [31:0] ew, input string req);
        cmp_valid = 1; cmp_asid = a; cmp_addr = ad; cmp_shared = sh; cmp_fault = f;
        @(negedge clk);
        chk({req, " cmp_done"}, 32'(cmp_done), 32'(edone));
        if (edone) chk({req, " cmp_word"}, cmp_word, ew);
        nxt();
        cmp_valid = 0; cmp_fault = 0; cmp_shared = 0;
    endtask

    task automatic t_fill(input logic [3:0] a, input logic [15:0] ad);
        fill_valid = 1; fill_asid = a; fill_addr = ad;
        for (int k = 0; k < 4; k++) fill_data[k*32 +: 32] = mkw(a, ad, k);
        nxt();
        fill_valid = 0;
    endtask

    task automatic t_sq(input logic [3:0] a, input logic [15:0] ad);
        sq_valid = 1; sq_asid = a; sq_addr = ad;
        nxt();
        sq_valid = 0;
    endtask

    task automatic sc_reset();
        @(negedge clk);
        chk("R14 err", 32'(err_underflow), 0);
        chk("R14 init_ok idle", 32'(init_ok), 0);
        chk("R14 cmp_done idle", 32'(cmp_done), 0);
        chk("R14 rd idle", 32'(mem_rd_valid), 0);
        nxt();
    endtask

    task automatic sc_miss_merge();
        t_init(1, 16'h0104, 0, 1, 0, 1, "R3 first miss");
        t_init(1, 16'h0108, 0, 1, 1, 0, "R2 merge in flight");
        t_init(2, 16'h0100, 0, 1, 0, 1, "R1 other asid misses");
        t_init(1, 16'h0200, 0, 0, 0, 0, "R4 refused at capacity");
        t_init(1, 16'h010C, 0, 1, 1, 0, "R2 merge at capacity");
    endtask

    task automatic sc_stall_fill();
        t_cmp(1, 16'h0108, 1, 0, 0, 0, "R6 shared not held");
        t_cmp(1, 16'h0104, 0, 0, 0, 0, "R6 miss not filled");
        t_fill(1, 16'h0100);
        t_cmp(1, 16'h0104, 0, 0, 1, mkw(1, 16'h0100, 1), "R7 miss word1");
        t_cmp(1, 16'h0108, 1, 0, 1, mkw(1, 16'h0100, 2), "R7 shared word2");
        t_cmp(1, 16'h010C, 1, 0, 1, mkw(1, 16'h0100, 3), "R7 shared word3");
    endtask

    task automatic sc_blocked_fault();
        mem_blocked = 1;
        t_init(1, 16'h0100, 0, 0, 0, 0, "R5 blocked");
        mem_blocked = 0;
        t_init(3, 16'h0500, 1, 1, 0, 0, "R10 fault start");
        t_cmp(3, 16'h0500, 0, 1, 1, 0, "R10 fault complete");
        t_init(1, 16'h0100, 0, 1, 1, 0, "R10 held block intact");
        t_cmp(1, 16'h0100, 1, 0, 1, mkw(1, 16'h0100, 0), "R7 word0");
    endtask

    task automatic sc_squash();
        t_sq(2, 16'h0100);
        t_fill(2, 16'h0100);
        t_init(2, 16'h0104, 0, 1, 0, 1, "R9 freed entry rereads");
        t_init(1, 16'h0100, 0, 1, 1, 0, "R9 held hit");
        t_sq(1, 16'h0100);
        t_init(1, 16'h0300, 0, 1, 0, 1, "R9 held waiter released");
    endtask

    task automatic sc_lru();
        t_fill(2, 16'h0100);
        t_fill(1, 16'h0300);
        t_cmp(2, 16'h0104, 0, 0, 1, mkw(2, 16'h0100, 1), "R8 move in");
        t_init(1, 16'h0100, 0, 1, 1, 0, "R8 reference lru");
        t_cmp(1, 16'h0300, 0, 0, 1, mkw(1, 16'h0300, 0), "R8 evicting completion");
        t_init(2, 16'h0100, 0, 1, 0, 1, "R8 unreferenced victim gone");
        t_cmp(1, 16'h0100, 1, 0, 1, mkw(1, 16'h0100, 0), "R8 referenced kept");
        t_init(1, 16'h0304, 0, 1, 1, 0, "R8 new block held");
        t_cmp(1, 16'h0304, 1, 0, 1, mkw(1, 16'h0300, 1), "R8 touch");
        t_fill(2, 16'h0100);
        t_cmp(2, 16'h0100, 0, 0, 1, mkw(2, 16'h0100, 0), "R8 evict lru");
        t_init(1, 16'h0308, 0, 1, 1, 0, "R8 mru kept");
        t_init(1, 16'h0100, 0, 1, 0, 1, "R8 lru evicted");
    endtask

    task automatic sc_priority();
        init_valid = 1; init_asid = 1; init_addr = 16'h0700;
        cmp_valid = 1; cmp_asid = 3; cmp_fault = 1;
        @(negedge clk);
        chk("R13 start loses", 32'(init_ok), 0);
        chk("R13 no read", 32'(mem_rd_valid), 0);
        chk("R13 cmp wins", 32'(cmp_done), 1);
        nxt();
        init_valid = 0;
        sq_valid = 1; sq_asid = 5; sq_addr = 16'h0900;
        @(negedge clk);
        chk("R13 cmp loses to squash", 32'(cmp_done), 0);
        nxt();
        sq_valid = 0; cmp_valid = 0; cmp_fault = 0;
    endtask

    task automatic sc_flush();
        flush = 1;
        nxt();
        flush = 0;
        t_init(1, 16'h0308, 0, 1, 0, 1, "R11 flushed block rereads");
    endtask

    task automatic sc_underflow();
        chk("R12 err clear", 32'(err_underflow), 0);
        t_fill(1, 16'h0300);
        t_cmp(1, 16'h0308, 0, 0, 1, mkw(1, 16'h0300, 2), "R12 setup");
        t_sq(1, 16'h0300);
        @(negedge clk);
        chk("R12 err set", 32'(err_underflow), 1);
        nxt();
        @(negedge clk);
        chk("R12 err sticky", 32'(err_underflow), 1);
        nxt();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        sc_reset();
        sc_miss_merge();
        sc_stall_fill();
        sc_blocked_fault();
        sc_squash();
        sc_lru();
        sc_priority();
        sc_flush();
        sc_underflow();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule